// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block holds the floating-point architectural registers of a core that supports both single and double precision: 32 entries of 64 bits. A single-precision result is stored with its upper half forced to all ones. A single-precision operand is handed out only if that upper half is intact; any other pattern yields the canonical single-precision NaN. Reads are combinational. Writes commit on the rising clock edge.

When the "floats in integer registers" mode input is high, all operand traffic is steered to an external integer register file. The FP array is then left alone. With a 32-bit integer datapath, a double-precision operand occupies an even/odd integer register pair. The integer file sits outside the block: the block drives its read indices and write lanes and takes its read data back combinationally.

Each committed write to the FP array produces a one-cycle strobe toward the status register. With that strobe come the Dirty code for the FP-state field and a set request for the summary-dirty bit.

Top module: `fpreg_box_file`

## Requirements
- R1: After a synchronous active-low reset, every FP register reads as 64 zero bits, and `st_wr`, `st_fs` and `st_sd` are all 0.
- R2: With `zfinx_en`=0, a write with `wr_dp`=0 stores `{32'hFFFF_FFFF, wr_data[31:0]}`. A later double read (`rd_dp`=1) of that index returns exactly this value.
- R3: With `zfinx_en`=0, a single read (`rd_dp`=0) of a register whose bits [63:32] are all ones returns `{32'h0, bits[31:0]}`.
- R4: With `zfinx_en`=0, a single read of a register whose upper half is not all ones returns `{32'h0, 32'h7FC0_0000}`.
- R5: With `zfinx_en`=0, a double write stores `wr_data` unchanged, and a double read returns all 64 bits.
- R6: A read of the index being written in the same cycle returns the value held before the write. The new value is visible from the next cycle.
- R7: Exactly one cycle after each edge that commits a write with `zfinx_en`=0, `st_wr`=1, `st_fs`=2'b11 and `st_sd`=1. In every other cycle all three are 0.
- R8: With `zfinx_en`=1, a single read returns `{32'h0, x[idx]}` with no boxing check. A single write drives lane 0 of the integer write port (`xrf_wr_en`=2'b01) with index `wr_idx` and data `wr_data[31:0]`.
- R9: With `zfinx_en`=1 and an even nonzero index i, a double read returns `{x[i+1], x[i]}`. A double write enables both lanes (`xrf_wr_en`=2'b11): lane 0 carries i and the low word, lane 1 carries i+1 and the high word.
- R10: With `zfinx_en`=1, a double read of index 0 returns 64 zero bits. A double write to index 0 enables no integer lane and raises no illegal flag.
- R11: With `zfinx_en`=1, a double access to an odd index raises the matching illegal flag (`rd_illegal`/`wr_illegal`). Such a read returns `64'h7FF8_0000_0000_0000`. Such a write enables no integer lane.
- R12: With `zfinx_en`=1, writes leave the FP array unchanged and raise no dirty strobe. With `zfinx_en`=0, `xrf_wr_en` stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zfinx_en | input | 1 | 1 = FP operands live in the integer register file |
| rd_idx | input | NRD x 5 | Read index per read port |
| rd_dp | input | NRD | Per read port: 1 = double, 0 = single |
| rd_data | output | NRD x 64 | Read data; single results occupy bits [31:0] |
| rd_illegal | output | NRD | Odd index on a paired double read |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write index |
| wr_dp | input | 1 | 1 = double write, 0 = single write |
| wr_data | input | 64 | Write data; singles use bits [31:0] |
| wr_illegal | output | 1 | Odd index on a paired double write |
| xrf_rd_idx | output | NRD x 2 x 5 | Integer file read index, lane 0 low word, lane 1 high word |
| xrf_rd_data | input | NRD x 2 x XLEN | Integer file read data per lane |
| xrf_wr_en | output | 2 | Integer file write enable per lane |
| xrf_wr_idx | output | 2 x 5 | Integer file write index per lane |
| xrf_wr_data | output | 2 x XLEN | Integer file write data per lane |
| st_wr | output | 1 | Status update strobe |
| st_fs | output | 2 | FP-state code carried with the strobe (2'b11 = Dirty) |
| st_sd | output | 1 | Summary-dirty set request carried with the strobe |

## Verification
The bench first targets the boxing boundary. A single read right after a double write must give the canonical single NaN; a design that skips the upper-half check would leak raw low bits. It then aims at read-during-write on the same index, where a bypassing design would return the new value one cycle early.

In paired mode the bench drives index 0 and odd indices. A design that mishandled them would write the integer file, or return a pair straddling two operands instead of zeros or the canonical double NaN. The dirty strobe is checked every cycle for the one-cycle lag and for silence under paired-mode writes. A design that also flagged integer-side writes, or held the strobe, would trip those checks.

// File: rtl/fprf_pkg.sv
`timescale 1ns/1ps
// Shared constants and boxing helpers for the FP register file.
// Assumes single precision is 32 bits carried inside a 64-bit register.
package fprf_pkg;
    localparam int SP_W = 32;
    localparam int DP_W = 64;
    localparam logic [SP_W-1:0] CANON_NAN_S = 32'h7FC0_0000;
    localparam logic [DP_W-1:0] CANON_NAN_D = 64'h7FF8_0000_0000_0000;
    localparam logic [1:0] FS_DIRTY = 2'b11;

    // Place a single value in a wide register with an all-ones upper half.
    function automatic logic [DP_W-1:0] nan_box(input logic [SP_W-1:0] v);
        return {{(DP_W-SP_W){1'b1}}, v};
    endfunction

    // Extract a single value, replacing a badly boxed one by the canonical NaN.
    function automatic logic [SP_W-1:0] nan_unbox(input logic [DP_W-1:0] v);
        return (&v[DP_W-1:SP_W]) ? v[SP_W-1:0] : CANON_NAN_S;
    endfunction
endpackage

// File: rtl/fprf_store.sv
`timescale 1ns/1ps
// Storage array of the FP registers with NRD combinational read ports.
// Assumes at most one write per cycle; reads see the pre-write contents.
module fprf_store #(
    parameter int NREGS = 32,
    parameter int NRD   = 2,
    parameter int IDXW  = $clog2(NREGS),
    parameter int W     = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDXW-1:0]           widx,
    input  logic [W-1:0]              wdata,
    input  logic [NRD-1:0][IDXW-1:0]  ridx,
    output logic [NRD-1:0][W-1:0]     rval
);
    logic [W-1:0] regs [NREGS];

    // Clear all entries on reset, otherwise commit the single write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (widx == IDXW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Combinational lookup for read port p.
        assign rval[p] = regs[ridx[p]];
    end
endmodule

// File: rtl/fprf_rd_lane.sv
`timescale 1ns/1ps
// One read port: unboxes FP-array singles or assembles integer-file operands.
// Assumes XLEN is 32 (pairs for doubles) or 64 (one register per operand).
module fprf_rd_lane
    import fprf_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = 5
) (
    input  logic              zfinx_en,
    input  logic [IDXW-1:0]   idx,
    input  logic              dp,
    input  logic [DP_W-1:0]   fp_val,
    input  logic [XLEN-1:0]   x_lo,
    input  logic [XLEN-1:0]   x_hi,
    output logic [IDXW-1:0]   x_lo_idx,
    output logic [IDXW-1:0]   x_hi_idx,
    output logic [DP_W-1:0]   data,
    output logic              illegal
);
    if (XLEN == 32) begin : g_pair
        // Even/odd pairing: low word at idx, high word at idx with bit 0 set.
        always_comb begin
            x_lo_idx = idx;
            x_hi_idx = {idx[IDXW-1:1], 1'b1};
            illegal  = 1'b0;
            if (!zfinx_en) begin
                data = dp ? fp_val : {{(DP_W-SP_W){1'b0}}, nan_unbox(fp_val)};
            end else if (!dp) begin
                data = {{(DP_W-SP_W){1'b0}}, x_lo};
            end else if (idx[0]) begin
                illegal = 1'b1;
                data    = CANON_NAN_D;
            end else if (idx == '0) begin
                data = '0;
            end else begin
                data = {x_hi, x_lo};
            end
        end
    end else begin : g_wide
        // One wide integer register per operand; second lane idle.
        always_comb begin
            x_lo_idx = idx;
            x_hi_idx = '0;
            illegal  = 1'b0;
            if (!zfinx_en) begin
                data = dp ? fp_val : {{(DP_W-SP_W){1'b0}}, nan_unbox(fp_val)};
            end else if (!dp) begin
                data = {{(DP_W-SP_W){1'b0}}, x_lo[SP_W-1:0]};
            end else begin
                data = DP_W'(x_lo);
            end
        end
    end
endmodule

// File: rtl/fprf_wr_route.sv
`timescale 1ns/1ps
// Write steering: boxes singles into the FP array, or splits operands onto
// the integer-file write lanes. Assumes XLEN is 32 or 64.
module fprf_wr_route
    import fprf_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = 5
) (
    input  logic                      wr_en,
    input  logic                      zfinx_en,
    input  logic [IDXW-1:0]           idx,
    input  logic                      dp,
    input  logic [DP_W-1:0]           data,
    output logic                      fp_we,
    output logic [DP_W-1:0]           fp_wdata,
    output logic [1:0]                x_en,
    output logic [1:0][IDXW-1:0]      x_idx,
    output logic [1:0][XLEN-1:0]      x_data,
    output logic                      illegal
);
    // Boxed or raw value destined for the FP array.
    assign fp_wdata = dp ? data : nan_box(data[SP_W-1:0]);

    if (XLEN == 32) begin : g_pair
        // Pair writes need an even nonzero index; index 0 is silently dropped.
        always_comb begin
            fp_we     = 1'b0;
            x_en      = 2'b00;
            illegal   = 1'b0;
            x_idx[0]  = idx;
            x_idx[1]  = {idx[IDXW-1:1], 1'b1};
            x_data[0] = data[SP_W-1:0];
            x_data[1] = data[DP_W-1:SP_W];
            if (wr_en) begin
                if (!zfinx_en) begin
                    fp_we = 1'b1;
                end else if (!dp) begin
                    x_en = 2'b01;
                end else if (idx[0]) begin
                    illegal = 1'b1;
                end else if (idx != '0) begin
                    x_en = 2'b11;
                end
            end
        end
    end else begin : g_wide
        // One lane carries the whole operand; singles are sign-extended.
        always_comb begin
            fp_we     = 1'b0;
            x_en      = 2'b00;
            illegal   = 1'b0;
            x_idx[0]  = idx;
            x_idx[1]  = '0;
            x_data[0] = dp ? XLEN'(data) : XLEN'({{(DP_W-SP_W){data[SP_W-1]}}, data[SP_W-1:0]});
            x_data[1] = '0;
            if (wr_en) begin
                if (!zfinx_en) fp_we = 1'b1;
                else           x_en  = 2'b01;
            end
        end
    end
endmodule

// File: rtl/fpreg_box_file.sv
`timescale 1ns/1ps
// Top of the NaN-boxing FP register file. Combines the storage array, one
// read lane per read port, the write router and the status-dirty strobe.
// Assumes the integer register file is external and answers reads
// combinationally on xrf_rd_data.
module fpreg_box_file
    import fprf_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int NRD   = 2,
    parameter int XLEN  = 32,
    parameter int IDXW  = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          zfinx_en,
    input  logic [NRD-1:0][IDXW-1:0]      rd_idx,
    input  logic [NRD-1:0]                rd_dp,
    output logic [NRD-1:0][63:0]          rd_data,
    output logic [NRD-1:0]                rd_illegal,
    input  logic                          wr_en,
    input  logic [IDXW-1:0]               wr_idx,
    input  logic                          wr_dp,
    input  logic [63:0]                   wr_data,
    output logic                          wr_illegal,
    output logic [NRD-1:0][1:0][IDXW-1:0] xrf_rd_idx,
    input  logic [NRD-1:0][1:0][XLEN-1:0] xrf_rd_data,
    output logic [1:0]                    xrf_wr_en,
    output logic [1:0][IDXW-1:0]          xrf_wr_idx,
    output logic [1:0][XLEN-1:0]          xrf_wr_data,
    output logic                          st_wr,
    output logic [1:0]                    st_fs,
    output logic                          st_sd
);
    logic                   fp_we;
    logic [DP_W-1:0]        fp_wdata;
    logic [NRD-1:0][DP_W-1:0] fp_rval;
    logic                   dirty_q;

    fprf_wr_route #(.XLEN(XLEN), .IDXW(IDXW)) u_wr (
        .wr_en    (wr_en),
        .zfinx_en (zfinx_en),
        .idx      (wr_idx),
        .dp       (wr_dp),
        .data     (wr_data),
        .fp_we    (fp_we),
        .fp_wdata (fp_wdata),
        .x_en     (xrf_wr_en),
        .x_idx    (xrf_wr_idx),
        .x_data   (xrf_wr_data),
        .illegal  (wr_illegal)
    );

    fprf_store #(.NREGS(NREGS), .NRD(NRD), .IDXW(IDXW), .W(DP_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fp_we),
        .widx  (wr_idx),
        .wdata (fp_wdata),
        .ridx  (rd_idx),
        .rval  (fp_rval)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        fprf_rd_lane #(.XLEN(XLEN), .IDXW(IDXW)) u_lane (
            .zfinx_en (zfinx_en),
            .idx      (rd_idx[p]),
            .dp       (rd_dp[p]),
            .fp_val   (fp_rval[p]),
            .x_lo     (xrf_rd_data[p][0]),
            .x_hi     (xrf_rd_data[p][1]),
            .x_lo_idx (xrf_rd_idx[p][0]),
            .x_hi_idx (xrf_rd_idx[p][1]),
            .data     (rd_data[p]),
            .illegal  (rd_illegal[p])
        );
    end

    // Register a one-cycle strobe for each write committed to the FP array.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty_q <= 1'b0;
        else        dirty_q <= fp_we;
    end

    assign st_wr = dirty_q;
    assign st_fs = dirty_q ? FS_DIRTY : 2'b00;
    assign st_sd = dirty_q;
endmodule

// File: rtl/fprf_box_chk.sv
`timescale 1ns/1ps
// Assertion checker for fpreg_box_file, attached by bind below.
// Pair-mode properties apply only when XLEN is 32.
module fprf_box_chk #(
    parameter int XLEN = 32,
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            zfinx_en,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx,
    input logic            wr_dp,
    input logic            wr_illegal,
    input logic [1:0]      xrf_wr_en,
    input logic            st_wr,
    input logic [1:0]      st_fs,
    input logic            st_sd,
    input logic            rd0_dp,
    input logic [31:0]     rd0_hi
);
    AST_DIRTY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !zfinx_en) |=> (st_wr && st_fs == 2'b11 && st_sd)); // R7
    AST_NO_SPURIOUS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !zfinx_en) |=> (!st_wr && st_fs == 2'b00 && !st_sd)); // R7
    AST_FP_MODE_NO_XWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !zfinx_en |-> xrf_wr_en == 2'b00); // R12
    AST_ZFINX_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && zfinx_en) |=> !st_wr); // R12
    AST_UNBOX_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!zfinx_en && !rd0_dp) |-> rd0_hi == 32'h0); // R4

    if (XLEN == 32) begin : g_pair
        AST_ODD_PAIR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && zfinx_en && wr_dp && wr_idx[0]) |-> (wr_illegal && xrf_wr_en == 2'b00)); // R11
        AST_ZERO_PAIR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && zfinx_en && wr_dp && wr_idx == '0) |-> (!wr_illegal && xrf_wr_en == 2'b00)); // R10
        AST_PAIR_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && zfinx_en && wr_dp && !wr_idx[0] && wr_idx != '0) |-> xrf_wr_en == 2'b11); // R9
    end
endmodule

bind fpreg_box_file fprf_box_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .zfinx_en   (zfinx_en),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_dp      (wr_dp),
    .wr_illegal (wr_illegal),
    .xrf_wr_en  (xrf_wr_en),
    .st_wr      (st_wr),
    .st_fs      (st_fs),
    .st_sd      (st_sd),
    .rd0_dp     (rd_dp[0]),
    .rd0_hi     (rd_data[0][63:32])
);

// File: tb/fpreg_box_file_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random traffic,
// compared with a bench-side model of both register files.
module fpreg_box_file_tb;
    localparam int NRD = 2;
    localparam int XL  = 32;
    localparam int IW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zfinx_en = 1'b0;
    logic [NRD-1:0][IW-1:0] rd_idx = '0;
    logic [NRD-1:0] rd_dp = '0;
    logic [NRD-1:0][63:0] rd_data;
    logic [NRD-1:0] rd_illegal;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic wr_dp = 1'b0;
    logic [63:0] wr_data = '0;
    logic wr_illegal;
    logic [NRD-1:0][1:0][IW-1:0] xrf_rd_idx;
    logic [NRD-1:0][1:0][XL-1:0] xrf_rd_data;
    logic [1:0] xrf_wr_en;
    logic [1:0][IW-1:0] xrf_wr_idx;
    logic [1:0][XL-1:0] xrf_wr_data;
    logic st_wr;
    logic [1:0] st_fs;
    logic st_sd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag_ovr = "";

    logic [63:0] fm [32];
    logic [31:0] xm [32];

    always #2.5 clk = ~clk;

    fpreg_box_file #(.NREGS(32), .NRD(NRD), .XLEN(XL)) u_dut (
        .clk(clk), .rst_n(rst_n), .zfinx_en(zfinx_en),
        .rd_idx(rd_idx), .rd_dp(rd_dp), .rd_data(rd_data), .rd_illegal(rd_illegal),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_dp(wr_dp), .wr_data(wr_data),
        .wr_illegal(wr_illegal), .xrf_rd_idx(xrf_rd_idx), .xrf_rd_data(xrf_rd_data),
        .xrf_wr_en(xrf_wr_en), .xrf_wr_idx(xrf_wr_idx), .xrf_wr_data(xrf_wr_data),
        .st_wr(st_wr), .st_fs(st_fs), .st_sd(st_sd)
    );

    // External integer register file: combinational read, x0 stays zero.
    always_comb begin
        for (int p = 0; p < NRD; p++)
            for (int l = 0; l < 2; l++)
                xrf_rd_data[p][l] = xm[xrf_rd_idx[p][l]];
    end

    always @(posedge clk) begin
        for (int l = 0; l < 2; l++)
            if (xrf_wr_en[l] && xrf_wr_idx[l] != 0) xm[xrf_wr_idx[l]] <= xrf_wr_data[l];
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {illegal, data} for a read, from the requirements.
    function automatic logic [64:0] exp_rd(input logic zf, input logic [4:0] i, input logic dp);
        if (!zf) begin
            if (dp) return {1'b0, fm[i]};
            if (fm[i][63:32] == 32'hFFFF_FFFF) return {1'b0, 32'h0, fm[i][31:0]};
            return {1'b0, 32'h0, 32'h7FC0_0000};
        end
        if (!dp) return {1'b0, 32'h0, xm[i]};
        if (i[0]) return {1'b1, 64'h7FF8_0000_0000_0000};
        if (i == 0) return {1'b0, 64'h0};
        return {1'b0, xm[i+1], xm[i]};
    endfunction

    function automatic string rd_tag(input logic zf, input logic [4:0] i, input logic dp);
        if (tag_ovr != "") return tag_ovr;
        if (!zf) return dp ? "R5" : ((fm[i][63:32] == 32'hFFFF_FFFF) ? "R3" : "R4");
        if (!dp) return "R8";
        if (i[0]) return "R11";
        return (i == 0) ? "R10" : "R9";
    endfunction

    // One cycle: check combinational outputs, commit, check the strobe.
    task automatic tick();
        logic [64:0] e;
        logic [1:0] xe;
        logic xill;
        logic dn;
        string wt;
        #1;
        for (int p = 0; p < NRD; p++) begin
            e = exp_rd(zfinx_en, rd_idx[p], rd_dp[p]);
            chk(rd_tag(zfinx_en, rd_idx[p], rd_dp[p]), rd_data[p], e[63:0]);
            chk(rd_tag(zfinx_en, rd_idx[p], rd_dp[p]), 64'(rd_illegal[p]), 64'(e[64]));
        end
        xe = 2'b00;
        xill = 1'b0;
        wt = "R12";
        if (wr_en && zfinx_en) begin
            if (!wr_dp) begin xe = 2'b01; wt = "R8"; end
            else if (wr_idx[0]) begin xill = 1'b1; wt = "R11"; end
            else if (wr_idx == 0) wt = "R10";
            else begin xe = 2'b11; wt = "R9"; end
        end
        chk(wt, 64'(xrf_wr_en), 64'(xe));
        chk(wt, 64'(wr_illegal), 64'(xill));
        if (xe[0]) begin
            chk(wt, 64'(xrf_wr_idx[0]), 64'(wr_idx));
            chk(wt, 64'(xrf_wr_data[0]), 64'(wr_data[31:0]));
        end
        if (xe[1]) begin
            chk(wt, 64'(xrf_wr_idx[1]), 64'(wr_idx + 5'd1));
            chk(wt, 64'(xrf_wr_data[1]), 64'(wr_data[63:32]));
        end
        dn = wr_en && !zfinx_en;
        @(posedge clk);
        if (dn) fm[wr_idx] = wr_dp ? wr_data : {32'hFFFF_FFFF, wr_data[31:0]};
        @(negedge clk);
        chk("R7", 64'({st_wr, st_fs, st_sd}), dn ? 64'hF : 64'h0);
    endtask

    task automatic set_wr(input logic en, input logic [4:0] i, input logic dp, input logic [63:0] d);
        wr_en = en; wr_idx = i; wr_dp = dp; wr_data = d;
    endtask

    task automatic set_rd(input int p, input logic [4:0] i, input logic dp);
        rd_idx[p] = i; rd_dp[p] = dp;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            fm[i] = '0;
            xm[i] = (i == 0) ? 32'h0 : 32'hA500_0000 + 32'(i);
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of strobe and every register.
        chk("R1", 64'({st_wr, st_fs, st_sd}), 64'h0);
        tag_ovr = "R1";
        for (int k = 0; k < 16; k++) begin
            set_rd(0, 5'(2*k), 1'b1); set_rd(1, 5'(2*k+1), 1'b1);
            tick();
        end
        // R6: read during write returns old (unboxed zero -> canonical single NaN).
        tag_ovr = "R6";
        set_wr(1, 5'd3, 1'b0, 64'h0123_4567_3F80_0000);
        set_rd(0, 5'd3, 1'b0); set_rd(1, 5'd3, 1'b1);
        tick();
        // R2 / R3: boxed storage and unboxed read.
        tag_ovr = "R2";
        set_wr(0, 5'd0, 1'b0, 64'h0);
        set_rd(0, 5'd3, 1'b1);
        set_rd(1, 5'd3, 1'b0);
        tick();
        tag_ovr = "";
        // R5 then R4: double write, single read of it gives canonical NaN.
        set_wr(1, 5'd5, 1'b1, 64'h1234_5678_9ABC_DEF0);
        set_rd(0, 5'd5, 1'b1);
        tick();
        set_wr(0, 5'd0, 1'b0, 64'h0);
        set_rd(0, 5'd5, 1'b1); set_rd(1, 5'd5, 1'b0);
        tick();
        // Integer-register mode corners: R8, R9, R10, R11, R12.
        zfinx_en = 1'b1;
        set_wr(1, 5'd7, 1'b0, 64'hDEAD_BEEF_4049_0FDB);
        set_rd(0, 5'd7, 1'b0); set_rd(1, 5'd0, 1'b1);
        tick();
        set_wr(1, 5'd10, 1'b1, 64'hCAFE_F00D_1111_2222);
        set_rd(0, 5'd7, 1'b0); set_rd(1, 5'd9, 1'b1);
        tick();
        set_wr(1, 5'd0, 1'b1, 64'hFFFF_0000_FFFF_0000);
        set_rd(0, 5'd10, 1'b1); set_rd(1, 5'd0, 1'b1);
        tick();
        set_wr(1, 5'd9, 1'b1, 64'h5555_6666_7777_8888);
        set_rd(0, 5'd9, 1'b1); set_rd(1, 5'd8, 1'b1);
        tick();
        set_wr(0, 5'd0, 1'b0, 64'h0);
        set_rd(0, 5'd9, 1'b0); set_rd(1, 5'd10, 1'b1);
        tick();
        // R12: FP array untouched by the integer-mode writes above.
        zfinx_en = 1'b0;
        tag_ovr = "R12";
        set_rd(0, 5'd7, 1'b1); set_rd(1, 5'd10, 1'b1);
        tick();
        tag_ovr = "";
        // Seeded random mix of modes, widths and indices.
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 16) == 0) zfinx_en = ~zfinx_en;
            set_wr(1'($urandom % 3 != 0), 5'($urandom), 1'($urandom),
                   {$urandom, $urandom});
            if (($urandom % 4) == 0) wr_data[63:32] = 32'hFFFF_FFFF;
            set_rd(0, 5'($urandom), 1'($urandom));
            set_rd(1, (($urandom % 4) == 0) ? wr_idx : 5'($urandom), 1'($urandom));
            tick();
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule